// File: doc/BRIEF.md
# Timer Channel Byte-Access Register Port

This unit sits between an 8-bit I/O-style bus and a bank of 16-bit down-counting timer channels. It decodes a two-bit port offset into one data port per channel plus one write-only command port. Command bytes set each channel's operating mode and its byte-access scheme. Data writes are built up into a 16-bit reload value, which is then handed to the channel with a one-cycle load strobe. Data reads split the channel's 16-bit count into two successive bytes.

A count-latch command takes a snapshot of a channel's live count. Reads of that channel then return the snapshot until its high byte has been read, even while the counter keeps running. If a snapshot is already held, a second latch command has no effect. The counters are outside this unit. Each channel's live count comes in on an input bus, and the unit drives out each channel's reload value, operating mode and load strobe.

Top module: `tbp_timer_port`

## Requirements
- R1: Offsets 0, 1 and 2 are the data ports of channels 0, 1 and 2, and offset 3 is the command port. In a command byte, bits 7:6 select the channel, bits 5:4 give the access field and bits 3:1 give the operating mode. A command whose access field is not 0 loads the mode onto that channel's `ch_mode` slice.
- R2: With access field 1 (low byte only), a data write replaces reload bits 7:0 and keeps bits 15:8.
- R3: With access field 2 (high byte only), a data write replaces reload bits 15:8 and keeps bits 7:0.
- R4: With access field 3 (low then high), data writes alternate. The first write fills bits 7:0 and the second fills bits 15:8. Only the second write requests a load. A command with access field 3 restarts the sequence at the low byte.
- R5: A load request is a pulse on that channel's bit of `ch_load`. It lasts exactly one cycle and comes in the cycle after the final byte write. The new reload value is already present on `ch_reload` in that cycle.
- R6: Data-port reads alternate, returning the low byte first and then the high byte. A command with a non-zero access field restarts the read order at the low byte.
- R7: A command with access field 0 copies the live count into a snapshot, provided no snapshot is held. Reads then return the snapshot regardless of later changes to the count. The command leaves the mode and the access scheme unchanged.
- R8: The snapshot is released when its high byte is read. Later reads return the live count.
- R9: A latch command that arrives while a snapshot is held leaves the held value unchanged.
- R10: A command byte with channel select 3 changes no mode, reload, load strobe, write order or read order.
- R11: A read of the command port returns 0x00 and does not advance any channel's read order.
- R12: After reset, every reload value and mode is zero and no load is requested. Every channel is in low-then-high access, and both its write order and its read order start at the low byte. No snapshot is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Port offset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle that `bus_rd` is high; zero otherwise |
| ch_count | input | NUM_CH*16 | Live count of each channel; channel i at bits 16i+15:16i |
| ch_reload | output | NUM_CH*16 | Reload value of each channel |
| ch_mode | output | NUM_CH*3 | Operating mode of each channel |
| ch_load | output | NUM_CH | One-cycle load request, one bit per channel |

## Verification
The bench builds the unit with its default NUM_CH of 3. At that width every select value from 0 to 2 reaches a real channel, and select 3 falls on the unused read-back code. This exercises the case where a command must be dropped even though its byte is well formed. Three channels also let each test leave one channel mid-sequence, such as waiting for a high byte or holding a snapshot, while another channel is driven. This shows that write order, read order and latch state are kept separately for each channel.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;
    localparam int SEL_W  = 2;

    localparam logic [SEL_W-1:0] CMD_PORT = 2'd3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_LOHI  = 2'd3
    } acc_e;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } cmd_t;

    function automatic logic [CNT_W-1:0] put_byte(input logic [CNT_W-1:0] v,
                                                  input logic hi,
                                                  input logic [BYTE_W-1:0] b);
        logic [CNT_W-1:0] r;
        r = v;
        if (hi) r[CNT_W-1:BYTE_W] = b;
        else    r[BYTE_W-1:0]     = b;
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] get_byte(input logic [CNT_W-1:0] v,
                                                   input logic hi);
        return hi ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/tbp_decode.sv
module tbp_decode
    import tbp_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic [SEL_W-1:0]  bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [NUM_CH-1:0] cmd_we,
    output logic [NUM_CH-1:0] data_we,
    output logic [NUM_CH-1:0] data_re,
    output cmd_t              cmd
);
    logic is_cmd;

    assign cmd    = cmd_t'(bus_wdata);
    assign is_cmd = bus_wr && (bus_addr == CMD_PORT);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        localparam logic [SEL_W-1:0] IDX = SEL_W'(i);
        assign cmd_we[i]  = is_cmd && (cmd.sel == IDX);
        assign data_we[i] = bus_wr && (bus_addr == IDX);
        assign data_re[i] = bus_rd && (bus_addr == IDX);
    end
endmodule

// File: rtl/tbp_chan.sv
module tbp_chan
    import tbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  acc_e              cmd_acc,
    input  logic [MODE_W-1:0] cmd_mode,
    input  logic              data_we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              data_re,
    input  logic [CNT_W-1:0]  count_in,
    output logic [CNT_W-1:0]  reload,
    output logic [MODE_W-1:0] mode,
    output logic              load,
    output logic [BYTE_W-1:0] rd_byte
);
    acc_e              acc_q;
    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  reload_q;
    logic [CNT_W-1:0]  snap_q;
    logic              snap_held_q;
    logic              wr_hi_q;
    logic              rd_hi_q;
    logic              load_q;

    logic [CNT_W-1:0]  rd_src;

    assign rd_src  = snap_held_q ? snap_q : count_in;
    assign rd_byte = get_byte(rd_src, rd_hi_q);
    assign reload  = reload_q;
    assign mode    = mode_q;
    assign load    = load_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q       <= ACC_LOHI;
            mode_q      <= '0;
            reload_q    <= '0;
            snap_q      <= '0;
            snap_held_q <= 1'b0;
            wr_hi_q     <= 1'b0;
            rd_hi_q     <= 1'b0;
            load_q      <= 1'b0;
        end else begin
            load_q <= 1'b0;

            if (data_re) begin
                rd_hi_q <= !rd_hi_q;
                if (rd_hi_q && snap_held_q) snap_held_q <= 1'b0;
            end

            if (cmd_we) begin
                if (cmd_acc == ACC_LATCH) begin
                    if (!snap_held_q) begin
                        snap_q      <= count_in;
                        snap_held_q <= 1'b1;
                    end
                end else begin
                    acc_q   <= cmd_acc;
                    mode_q  <= cmd_mode;
                    wr_hi_q <= 1'b0;
                    rd_hi_q <= 1'b0;
                end
            end else if (data_we) begin
                unique case (acc_q)
                    ACC_LO: begin
                        reload_q <= put_byte(reload_q, 1'b0, wdata);
                        load_q   <= 1'b1;
                    end
                    ACC_HI: begin
                        reload_q <= put_byte(reload_q, 1'b1, wdata);
                        load_q   <= 1'b1;
                    end
                    ACC_LOHI: begin
                        reload_q <= put_byte(reload_q, wr_hi_q, wdata);
                        wr_hi_q  <= !wr_hi_q;
                        load_q   <= wr_hi_q;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tbp_timer_port.sv
module tbp_timer_port
    import tbp_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    input  logic [NUM_CH*16-1:0]    ch_count,
    output logic [NUM_CH*16-1:0]    ch_reload,
    output logic [NUM_CH*3-1:0]     ch_mode,
    output logic [NUM_CH-1:0]       ch_load
);
    logic [NUM_CH-1:0] cmd_we;
    logic [NUM_CH-1:0] data_we;
    logic [NUM_CH-1:0] data_re;
    cmd_t              cmd;
    logic [BYTE_W-1:0] rd_bytes [NUM_CH];

    tbp_decode #(.NUM_CH(NUM_CH)) u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .cmd_we   (cmd_we),
        .data_we  (data_we),
        .data_re  (data_re),
        .cmd      (cmd)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tbp_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .cmd_we  (cmd_we[i]),
            .cmd_acc (cmd.acc),
            .cmd_mode(cmd.mode),
            .data_we (data_we[i]),
            .wdata   (bus_wdata),
            .data_re (data_re[i]),
            .count_in(ch_count[i*CNT_W +: CNT_W]),
            .reload  (ch_reload[i*CNT_W +: CNT_W]),
            .mode    (ch_mode[i*MODE_W +: MODE_W]),
            .load    (ch_load[i]),
            .rd_byte (rd_bytes[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (data_re[i]) bus_rdata = rd_bytes[i];
        end
    end
endmodule

// File: rtl/tbp_chk.sv
module tbp_chk #(
    parameter int NUM_CH = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic [1:0]           bus_addr,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [7:0]           bus_wdata,
    input logic [7:0]           bus_rdata,
    input logic [NUM_CH*16-1:0] ch_reload,
    input logic [NUM_CH*3-1:0]  ch_mode,
    input logic [NUM_CH-1:0]    ch_load
);
    // R11
    cmd_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd3) |-> (bus_rdata == 8'h00));

    // R5
    load_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_load));

    // R10
    readback_mode_chk: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == 2'd3 && bus_wdata[7:6] == 2'd3) |-> $stable(ch_mode));

    // R10
    readback_load_chk: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == 2'd3 && bus_wdata[7:6] == 2'd3) |-> (ch_load == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R5
        load_after_write_chk: assert property (@(posedge clk) disable iff (rst)
            ch_load[i] |-> $past(bus_wr && bus_addr == 2'(i)));

        // R5
        load_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
            ch_load[i] |=> !ch_load[i]);

        // R2
        reload_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(bus_wr && bus_addr == 2'(i)) |-> $stable(ch_reload[i*16 +: 16]));
    end
endmodule

bind tbp_timer_port tbp_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .ch_reload(ch_reload),
    .ch_mode  (ch_mode),
    .ch_load  (ch_load)
);

// File: tb/tbp_timer_port_test.sv
module tbp_timer_port_test;
    localparam int NCH = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic [NCH*16-1:0] ch_count = '0;
    logic [NCH*16-1:0] ch_reload;
    logic [NCH*3-1:0]  ch_mode;
    logic [NCH-1:0]    ch_load;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    tbp_timer_port #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_count(ch_count),
        .ch_reload(ch_reload), .ch_mode(ch_mode), .ch_load(ch_load)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] reload_of(input int c);
        return ch_reload[c*16 +: 16];
    endfunction

    function automatic logic [2:0] mode_of(input int c);
        return ch_mode[c*3 +: 3];
    endfunction

    task automatic set_count(input int c, input logic [15:0] v);
        ch_count[c*16 +: 16] = v;
    endtask

    // write one byte; returns after the edge, with the load strobe visible
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] b;
        set_count(0, 16'h1234);
        for (int c = 0; c < NCH; c++) begin
            chk("R12 reload zero", reload_of(c), 16'h0000);
            chk("R12 mode zero", 16'(mode_of(c)), 16'h0000);
        end
        chk("R12 no load", 16'(ch_load), 16'h0000);
        bus_read(2'd0, b); chk("R12 low first", 16'(b), 16'h0034);
        bus_read(2'd0, b); chk("R12 then high", 16'(b), 16'h0012);
        // default low-then-high access
        bus_write(2'd0, 8'h21); chk("R12 lohi no load", 16'(ch_load), 16'h0000);
        bus_write(2'd0, 8'h43); chk("R12 lohi load", 16'(ch_load), 16'h0001);
        chk("R12 lohi reload", reload_of(0), 16'h4321);
    endtask

    task automatic t_lohi;
        bus_write(2'd3, 8'h34);               // ch0, access 3, mode 2
        chk("R1 mode set", 16'(mode_of(0)), 16'h0002);
        bus_write(2'd0, 8'hCD);
        chk("R4 no load on low", 16'(ch_load), 16'h0000);
        chk("R4 low byte placed", reload_of(0), 16'h43CD);
        bus_write(2'd0, 8'hAB);
        chk("R4 load after high", 16'(ch_load), 16'h0001);
        chk("R5 reload with pulse", reload_of(0), 16'hABCD);
        @(negedge clk);
        chk("R5 pulse one cycle", 16'(ch_load), 16'h0000);
        // restart order: low write, then command, then low again
        bus_write(2'd0, 8'h11);
        bus_write(2'd3, 8'h34);
        bus_write(2'd0, 8'h22);
        chk("R4 restart low", reload_of(0), 16'hAB22);
        chk("R4 restart no load", 16'(ch_load), 16'h0000);
        bus_write(2'd0, 8'h33);
        chk("R4 restart high", reload_of(0), 16'h3322);
    endtask

    task automatic t_single;
        bus_write(2'd3, 8'h56);               // ch1, access 1, mode 3
        chk("R1 ch1 mode", 16'(mode_of(1)), 16'h0003);
        bus_write(2'd1, 8'h77);
        chk("R2 low only", reload_of(1), 16'h0077);
        chk("R2 load", 16'(ch_load), 16'h0002);
        bus_write(2'd3, 8'h66);               // ch1, access 2
        bus_write(2'd1, 8'h99);
        chk("R3 high only", reload_of(1), 16'h9977);
        chk("R3 load", 16'(ch_load), 16'h0002);
        bus_write(2'd3, 8'h56);
        bus_write(2'd1, 8'h11);
        chk("R2 keeps high", reload_of(1), 16'h9911);
        chk("R1 ch0 untouched", reload_of(0), 16'h3322);
    endtask

    task automatic t_read;
        logic [7:0] b;
        set_count(2, 16'hBEEF);
        bus_read(2'd2, b); chk("R6 low", 16'(b), 16'h00EF);
        bus_read(2'd2, b); chk("R6 high", 16'(b), 16'h00BE);
        bus_read(2'd2, b); chk("R6 low again", 16'(b), 16'h00EF);
        bus_write(2'd3, 8'hB0);               // ch2, access 3, mode 0
        bus_read(2'd2, b); chk("R6 cmd restarts low", 16'(b), 16'h00EF);
        bus_read(2'd3, b); chk("R11 cmd port zero", 16'(b), 16'h0000);
        bus_read(2'd2, b); chk("R11 order kept", 16'(b), 16'h00BE);
    endtask

    task automatic t_latch;
        logic [7:0] b;
        set_count(1, 16'h1357);
        bus_write(2'd3, 8'h40);               // latch ch1
        chk("R7 mode kept", 16'(mode_of(1)), 16'h0003);
        set_count(1, 16'h2468);
        bus_read(2'd1, b); chk("R7 snapshot low", 16'(b), 16'h0057);
        bus_write(2'd3, 8'h40);               // latch while held
        bus_read(2'd1, b); chk("R9 snapshot kept", 16'(b), 16'h0013);
        bus_read(2'd1, b); chk("R8 live low", 16'(b), 16'h0068);
        bus_read(2'd1, b); chk("R8 live high", 16'(b), 16'h0024);
        bus_write(2'd1, 8'h55);
        chk("R7 access kept", reload_of(1), 16'h9955);
    endtask

    task automatic t_readback;
        logic [7:0] b;
        bus_write(2'd0, 8'h44);               // ch0 now waits for high byte
        set_count(0, 16'hA5C3);
        bus_read(2'd0, b);                    // ch0 read order now high
        bus_write(2'd3, 8'hF4);
        chk("R10 no load", 16'(ch_load), 16'h0000);
        chk("R10 mode0", 16'(mode_of(0)), 16'h0002);
        chk("R10 mode1", 16'(mode_of(1)), 16'h0003);
        chk("R10 mode2", 16'(mode_of(2)), 16'h0000);
        chk("R10 reload", reload_of(0), 16'h3344);
        bus_read(2'd0, b); chk("R10 read order", 16'(b), 16'h00A5);
        bus_write(2'd0, 8'h66);
        chk("R10 write order", reload_of(0), 16'h6644);
        chk("R10 load after", 16'(ch_load), 16'h0001);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_lohi;
        t_single;
        t_read;
        t_latch;
        t_readback;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule